// File: doc/BRIEF.md
# Serial Clock Divider with Settle Flag

This block produces the serial clock for a quad-capable serial flash controller. It divides a fast base clock by a programmable 8-bit ratio. A single 16-bit control word is written through a simple write strobe and is always visible on a read-back bus. The word holds a clock-enable bit, a read-only settle flag and the divider field. Alongside the clock level, the block emits a one-cycle tick strobe each time the serial clock changes level. A downstream shifter uses that strobe to shift or sample data.

Changing the divider withdraws the settle flag. The new ratio is taken up only at the end of the half-period in progress, so the output never carries a shortened pulse. The flag returns once the clock has run two full periods at the new ratio. Software polls the flag before it starts any traffic. While the clock is disabled, the output rests at a level chosen by an idle-polarity input, and a new divider is adopted at once.

Top module: `sclk_divider`

## Requirements
- R1: Out of reset the read-back word is 0x0002: enable 0 at bit 0, settle flag 1 at bit 1, divider 0 at bits 15:8. The tick is low and the serial clock sits at the idle-polarity level.
- R2: The read-back word shows enable at bit 0, the settle flag at bit 1 and the stored divider at bits 15:8, and bits 7:2 read 0. A write (write strobe high at a clock edge) updates enable and divider on that edge. Written bits 7:1 are discarded.
- R3: While enabled with effective divider N, the serial clock changes level every N base-clock cycles, so one period is 2N cycles. The first change after enabling starts from the idle level. The tick is high exactly in the cycles in which the serial clock has just changed level.
- R4: While enable reads 0, the serial clock is driven to the idle-polarity level from the edge after the enable bit clears, and no tick is produced.
- R5: A write whose divider field differs from the stored divider clears the settle flag on the write edge. A write with an unchanged divider leaves the flag as it was.
- R6: While enabled, a new divider takes effect only at the end of the half-period in progress. That half-period keeps the old length, and the next one has the new length.
- R7: While enabled, the settle flag returns on the edge that ends the fourth half-period timed with the new divider, counted after the boundary at which that divider was adopted.
- R8: While disabled, a changed divider is adopted on the edge after the write, and the settle flag is set again on that same edge. Disabling the clock while a change is still settling also sets the flag.
- R9: A divider value of 0 behaves as 1: the serial clock changes level on every base-clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| idle_pol | input | 1 | Level of the serial clock while disabled |
| rd_data | output | 16 | Control word read-back, including the settle flag |
| sclk | output | 1 | Serial clock output |
| tick | output | 1 | One-cycle strobe in each cycle after a serial clock level change |

## Verification
The divider is tried with ratios of 3, 0, 8, 2, 5 and 9, with the clock both enabled and disabled, and under both idle polarities. This separates a correct half-period length from an off-by-one, and separates the zero-as-one mapping from a stalled counter. A change written in the middle of a long half-period shows whether the new ratio is applied early, which would create a runt pulse, or at the boundary. Counting ticks while the settle flag is low pins the exact edge on which it returns. Rewrites of an unchanged divider, and disabling during the settle window, show that the flag is cleared only by a real change and that disabling restores it.

// File: rtl/sclkdiv_pkg.sv
// Shared field positions of the serial clock divider control word.
// Assumes the divider field is the top field of the word.
package sclkdiv_pkg;
    localparam int CTL_EN_BIT  = 0;   // clock enable, read/write
    localparam int CTL_STB_BIT = 1;   // settle flag, read-only
    localparam int CTL_DIV_LSB = 8;   // lowest bit of the divider field
endpackage

// File: rtl/sclkdiv_ctl_regs.sv
// Control register holding the enable bit and the requested divider.
// Assumes writes are single-cycle strobes; flags a divider change combinationally.
module sclkdiv_ctl_regs #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_en_bit,
    input  logic [DIV_W-1:0] wr_div,
    output logic             en_o,
    output logic [DIV_W-1:0] div_o,
    output logic             div_change_o
);
    logic             en_q;
    logic [DIV_W-1:0] div_q;

    // a write that carries a different divider starts a new settle cycle
    assign div_change_o = wr_en && (wr_div != div_q);
    assign en_o         = en_q;
    assign div_o        = div_q;

    // register the written enable bit and divider field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            div_q <= '0;
        end else if (wr_en) begin
            en_q  <= wr_en_bit;
            div_q <= wr_div;
        end
    end
endmodule

// File: rtl/sclkdiv_half_timer.sv
// Half-period timer: counts base cycles against the active divider and marks
// each half-period boundary. A requested divider is held pending and adopted at
// a boundary, or at once while disabled. Assumes divider 0 means 1.
module sclkdiv_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_req,
    input  logic             div_change,
    output logic             half_edge,
    output logic             load
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_act_q;
    logic             pend_q;

    function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
        return (d == '0) ? DIV_W'(1) : d;
    endfunction

    assign half_edge = en && (cnt_q == div_act_q - DIV_W'(1));
    assign load      = pend_q && (half_edge || !en);

    // cycle counter within the current half-period
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (!en || half_edge) cnt_q <= '0;
        else                       cnt_q <= cnt_q + DIV_W'(1);
    end

    // active divider, replaced only when a pending request is loaded
    always_ff @(posedge clk) begin
        if (!rst_n)    div_act_q <= DIV_W'(1);
        else if (load) div_act_q <= eff_div(div_req);
    end

    // pending flag: a fresh change wins over a load in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (div_change) pend_q <= 1'b1;
        else if (load)       pend_q <= 1'b0;
    end
endmodule

// File: rtl/sclkdiv_settle.sv
// Settle tracker: drops the flag on a divider change, arms when the new divider
// is adopted while running, and sets the flag after SETTLE_HALVES half-periods.
// While disabled the flag is set straight away.
module sclkdiv_settle #(
    parameter int SETTLE_HALVES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic div_change,
    input  logic load,
    input  logic half_edge,
    output logic stable_o
);
    localparam int SW = (SETTLE_HALVES > 1) ? $clog2(SETTLE_HALVES) : 1;

    logic          stable_q;
    logic          armed_q;
    logic [SW-1:0] halves_q;

    assign stable_o = stable_q;

    // settle state machine with change > adopt > disabled > counting priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_q <= 1'b1;
            armed_q  <= 1'b0;
            halves_q <= '0;
        end else if (div_change) begin
            stable_q <= 1'b0;
            armed_q  <= 1'b0;
            halves_q <= '0;
        end else if (load && en) begin
            armed_q  <= 1'b1;
            halves_q <= '0;
        end else if (!en) begin
            stable_q <= 1'b1;
            armed_q  <= 1'b0;
        end else if (armed_q && half_edge) begin
            if (halves_q == SW'(SETTLE_HALVES - 1)) begin
                stable_q <= 1'b1;
                armed_q  <= 1'b0;
            end else begin
                halves_q <= halves_q + SW'(1);
            end
        end
    end
endmodule

// File: rtl/sclk_divider.sv
// Serial clock divider top: control word, half-period timer, settle tracker
// and the registered clock and tick outputs. Assumes a single base clock and
// synchronous active-low reset.
module sclk_divider #(
    parameter  int DIV_W         = 8,
    parameter  int SETTLE_HALVES = 4,
    localparam int CW            = sclkdiv_pkg::CTL_DIV_LSB + DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    input  logic          idle_pol,
    output logic [CW-1:0] rd_data,
    output logic          sclk,
    output logic          tick
);
    import sclkdiv_pkg::*;

    logic             en;
    logic [DIV_W-1:0] div_req;
    logic             div_change;
    logic             half_edge;
    logic             load;
    logic             stable;
    logic             sclk_q;
    logic             tick_q;
    logic             unused_rsvd;

    // written bits between the settle flag and the divider are discarded
    assign unused_rsvd = ^wr_data[CTL_DIV_LSB-1:CTL_STB_BIT];

    sclkdiv_ctl_regs #(.DIV_W(DIV_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_en_bit    (wr_data[CTL_EN_BIT]),
        .wr_div       (wr_data[CTL_DIV_LSB +: DIV_W]),
        .en_o         (en),
        .div_o        (div_req),
        .div_change_o (div_change)
    );

    sclkdiv_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .div_req    (div_req),
        .div_change (div_change),
        .half_edge  (half_edge),
        .load       (load)
    );

    sclkdiv_settle #(.SETTLE_HALVES(SETTLE_HALVES)) u_settle (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .div_change (div_change),
        .load       (load),
        .half_edge  (half_edge),
        .stable_o   (stable)
    );

    // serial clock level and shifter tick, both registered
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sclk_q <= idle_pol;
            tick_q <= 1'b0;
        end else begin
            sclk_q <= sclk_q ^ half_edge;
            tick_q <= half_edge;
        end
    end

    // assemble the read-back word
    always_comb begin
        rd_data                         = '0;
        rd_data[CTL_EN_BIT]             = en;
        rd_data[CTL_STB_BIT]            = stable;
        rd_data[CTL_DIV_LSB +: DIV_W]   = div_req;
    end

    assign sclk = sclk_q;
    assign tick = tick_q;
endmodule

// File: rtl/sclk_divider_chk.sv
// Port-level properties of the serial clock divider, bound to the top module.
module sclk_divider_chk #(
    parameter int DIV_W = 8,
    parameter int CW    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_en_bit,
    input logic [DIV_W-1:0] wr_div,
    input logic             idle_pol,
    input logic [CW-1:0]    rd_data,
    input logic             sclk,
    input logic             tick
);
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (rd_data == CW'(2)) && !tick && (sclk == $past(idle_pol))); // R1

    AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[CW-1 -: DIV_W] == $past(wr_div)) && (rd_data[0] == $past(wr_en_bit))); // R2

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[CW-DIV_W-1:2] == '0); // R2

    AST_TICK_MARKS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (sclk != $past(sclk))); // R3

    AST_CHANGE_HAS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_data[0]) && (sclk != $past(sclk))) |-> tick); // R3

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_data[0]) |-> ((sclk == $past(idle_pol)) && !tick)); // R4

    AST_CHANGE_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_div != rd_data[CW-1 -: DIV_W])) |=> !rd_data[1]); // R5

    AST_SAME_DIV_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_div == rd_data[CW-1 -: DIV_W]) && rd_data[1]) |=> rd_data[1]); // R5
endmodule

bind sclk_divider sclk_divider_chk #(.DIV_W(DIV_W), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_en_bit (wr_data[0]),
    .wr_div    (wr_data[CW-1 -: DIV_W]),
    .idle_pol  (idle_pol),
    .rd_data   (rd_data),
    .sclk      (sclk),
    .tick      (tick)
);

// File: tb/sim_sclk_divider.sv
`timescale 1ns/1ps
// Bench: behavioural per-cycle model (scheduled toggle times, countdown of
// settle half-periods) compared every clock, plus directed checks.
module sim_sclk_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        idle_pol = 1'b0;
    logic [15:0] rd_data;
    logic        sclk;
    logic        tick;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    bit    cmp_on = 0;
    string phase  = "R1";

    always #2.5 clk = ~clk;

    sclk_divider u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .idle_pol(idle_pol), .rd_data(rd_data), .sclk(sclk), .tick(tick)
    );

    // ---------------- reference model ----------------
    int unsigned bcyc = 0;
    bit m_en, m_sclk, m_tick, m_stable, m_pend;
    int m_dreq, m_dact, m_left, m_next;

    function automatic int eff(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    always @(posedge clk) begin
        bit h, ld, chg, nxt_sclk;
        if (!rst_n) begin
            m_en = 0; m_dreq = 0; m_dact = 1; m_pend = 0; m_sclk = idle_pol;
            m_tick = 0; m_stable = 1; m_left = 0; m_next = 0;
        end else begin
            h   = m_en && (int'(bcyc) == m_next);
            ld  = m_pend && (h || !m_en);
            chg = wr_en && (int'(wr_data[15:8]) != m_dreq);
            nxt_sclk = !m_en ? idle_pol : (h ? !m_sclk : m_sclk);
            m_tick = h;
            if (ld) m_dact = eff(m_dreq);
            if (chg) begin m_stable = 0; m_left = 0; end
            else if (ld && m_en) m_left = 4;
            else if (!m_en) begin m_stable = 1; m_left = 0; end
            else if (h && m_left > 0) begin
                m_left--;
                if (m_left == 0) m_stable = 1;
            end
            if (chg) m_pend = 1; else if (ld) m_pend = 0;
            if (h || !m_en) m_next = int'(bcyc) + m_dact;
            if (wr_en) begin m_dreq = int'(wr_data[15:8]); m_en = wr_data[0]; end
            m_sclk = nxt_sclk;
        end
        bcyc++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            int act, exp;
            act = {rd_data, sclk, tick};
            exp = {m_dreq[7:0], 6'b0, m_stable, m_en, m_sclk, m_tick};
            chk(act == exp, phase, act, exp);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [15:0] w);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_tick(output int t);
        do @(negedge clk); while (!tick);
        t = int'(bcyc);
    endtask

    task automatic gap(output int g);
        int a, b;
        wait_tick(a);
        wait_tick(b);
        g = b - a;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int g, n, t0, t1, t2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1;
        @(negedge clk);
        // R1 reset state
        chk(rd_data == 16'h0002, "R1 rd_data", rd_data, 16'h0002);
        chk(sclk == 1'b0 && tick == 1'b0, "R1 sclk/tick", {sclk, tick}, 0);

        // R5 / R8: change while disabled
        phase = "R8";
        wr(16'h0300);
        chk(rd_data == 16'h0300, "R5 flag cleared", rd_data, 16'h0300);
        @(negedge clk);
        chk(rd_data == 16'h0302, "R8 flag back while disabled", rd_data, 16'h0302);

        // R2 reserved bits discarded, R5 same divider keeps flag, R3 ratio 3
        phase = "R3";
        wr(16'h03FF);
        chk(rd_data == 16'h0303, "R2 readback", rd_data, 16'h0303);
        gap(g);
        chk(g == 3, "R3 half period div 3", g, 3);
        chk(rd_data[1] == 1'b1, "R5 same divider keeps flag", rd_data[1], 1);

        // R9 / R7: divider 0 and settle timing
        phase = "R7";
        wr(16'h0001);
        chk(rd_data == 16'h0001, "R5 flag cleared running", rd_data, 16'h0001);
        n = 0;
        do begin
            @(negedge clk);
            if (tick) n++;
        end while (!rd_data[1]);
        chk(n == 5, "R7 ticks until settle", n, 5);
        phase = "R9";
        gap(g);
        chk(g == 1, "R9 divider 0 as 1", g, 1);

        // R6: change during a long half-period
        phase = "R6";
        wr(16'h0801);
        do @(negedge clk); while (!rd_data[1]);
        gap(g);
        chk(g == 8, "R3 half period div 8", g, 8);
        wait_tick(t0);
        repeat (2) @(negedge clk);
        wr(16'h0201);
        wait_tick(t1);
        wait_tick(t2);
        chk(t1 - t0 == 8, "R6 old half-period kept", t1 - t0, 8);
        chk(t2 - t1 == 2, "R6 new ratio after boundary", t2 - t1, 2);

        // R4: disabled clock rests at idle level
        phase = "R4";
        idle_pol = 1'b1;
        wr(16'h0200);
        @(negedge clk);
        chk(sclk == 1'b1 && tick == 1'b0, "R4 idle high", {sclk, tick}, 2);
        n = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (tick || !sclk) n++;
        end
        chk(n == 0, "R4 no activity while disabled", n, 0);

        // R8 with other polarity
        phase = "R8";
        wr(16'h0500);
        chk(rd_data == 16'h0500, "R5 flag cleared disabled", rd_data, 16'h0500);
        @(negedge clk);
        chk(rd_data == 16'h0502, "R8 adopt while disabled", rd_data, 16'h0502);

        // R3 first change starts from idle level
        phase = "R3";
        wr(16'h0501);
        wait_tick(t0);
        chk(sclk == 1'b0, "R3 first change leaves idle", sclk, 0);
        gap(g);
        chk(g == 5, "R3 half period div 5", g, 5);

        // R8 disable during settle window
        phase = "R8";
        wr(16'h0901);
        wr(16'h0900);
        repeat (2) @(negedge clk);
        chk(rd_data == 16'h0902, "R8 disable restores flag", rd_data, 16'h0902);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule